// File: doc/BRIEF.md
# Two-Way Set-Associative Byte Cache Controller

This block is a byte-addressed cache placed between a processor port and a main-memory port that moves one 32-bit word per handshake. The processor presents a byte address and either reads one byte or writes one byte. Each cache line carries one 32-bit block. Every set holds two lines. A block may sit in either line of the set that its address selects. Both lines are compared at the same time. Victims are chosen by one least-recently-used bit per set.

Two static control inputs select the mode at run time. `noWriteThrough` chooses write-back (high) or write-through (low). `cacheDisable` sends every access straight to memory. A flush request writes every dirty line back to memory, invalidates every line, and then pulses a done strobe. The processor holds its request until `cpuReady` is high for one cycle. It drops or changes the request in the next cycle. The set count is a parameter (`SET_W` index bits). The tag takes the address bits that remain above the set index, so `SET_W = 13` gives a 9-bit tag over a 24-bit address.

Top module: `setAssocCache`

## Requirements
- R1: The byte address splits into a tag (upper `ADDR_W-2-SET_W` bits), a set index (next `SET_W` bits) and a byte offset (bits 1:0). Addresses that differ only in the tag compete for the two lines of the same set.
- R2: A read hit returns byte `offset` of the stored word (offset 0 = bits 7:0) with `cpuReady` high and no memory request.
- R3: A read miss reads exactly one word from memory, fills a line, and returns the addressed byte. Two blocks of one set stay resident together.
- R4: On a miss with both lines valid, the line that was used less recently in that set is replaced. Hits and fills both count as uses.
- R5: In write-back mode, a write hit changes only the cache and marks the line dirty. A dirty victim is written to memory as a full word (`memBe` = 4'b1111) before the fill read.
- R6: A clean or invalid victim is never written to memory.
- R7: In write-through mode, a write hit updates the cache and writes memory with `memBe` one-hot at the byte offset (bit k set for offset k).
- R8: In write-through mode, a write miss writes memory only and allocates no line, so a later read of that block misses.
- R9: With `cacheDisable` high, every access goes to memory whether or not its block is cached, and a read returns the addressed byte of the word that memory returns.
- R10: A flush writes back every dirty line and leaves every line invalid. `flushDone` pulses for exactly one cycle.
- R11: After reset, every line is invalid and `cpuReady`, `memReq` and `flushDone` are low.
- R12: A memory request holds `memReq`, `memAddr` and `memWe` steady until `memAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cacheDisable | input | 1 | High: bypass the cache entirely |
| noWriteThrough | input | 1 | High: write-back, low: write-through |
| cpuReq | input | 1 | Processor access request, held until ready |
| cpuWe | input | 1 | Access is a byte write |
| cpuAddr | input | ADDR_W | Byte address |
| cpuWdata | input | 8 | Write byte |
| cpuRdata | output | 8 | Read byte, valid while cpuReady |
| cpuReady | output | 1 | Access completes this cycle |
| flushReq | input | 1 | Flush request, held until flushDone |
| flushDone | output | 1 | One-cycle flush completion |
| memReq | output | 1 | Memory word request |
| memWe | output | 1 | Memory request is a write |
| memAddr | output | ADDR_W-2 | Memory word address |
| memBe | output | 4 | Byte enables for a memory write |
| memWdata | output | 32 | Memory write word |
| memRdata | input | 32 | Memory read word, valid with memAck |
| memAck | input | 1 | Memory handshake completion |

## Verification
The bench fills one set with two blocks and then brings in a third. A controller with the LRU bit stuck or inverted would evict the block that was just touched, and a later hit on it would turn into a memory read. In write-back mode, it makes a line dirty and forces it out. A design that skips the write-back, writes clean victims, or reads before writing shows up in the memory write count, the write and read order, and the stored word. In write-through mode, it checks the one-hot byte enable and that a write miss does not allocate. A design that allocates there would satisfy the following read without a memory read. It also checks that bypass reaches memory even for a cached block, and that a flush writes exactly the dirty lines and then misses on every line.

// File: rtl/cacheCtrlPkg.sv
package cacheCtrlPkg;

  typedef enum logic [1:0] {
    SRC_CPU    = 2'd0,
    SRC_VICTIM = 2'd1,
    SRC_FLUSH  = 2'd2
  } memSrc_e;

  typedef struct packed {
    logic    writeByte;
    logic    setDirty;
    logic    fill;
    logic    lruTouch;
    logic    capture;
    logic    useCap;
    logic    flushClr;
    logic    flushAdv;
    logic    flushClean;
    memSrc_e memSrc;
  } strobes_t;

endpackage

// File: rtl/cacheDatapath.sv
module cacheDatapath
  import cacheCtrlPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SET_W  = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            stb,
  input  logic [ADDR_W-1:0]   cpuAddr,
  input  logic [7:0]          cpuWdata,
  output logic [7:0]          cpuRdata,
  output logic [ADDR_W-3:0]   memAddr,
  output logic [31:0]         memWdata,
  output logic [3:0]          memBe,
  input  logic [31:0]         memRdata,
  output logic                hit,
  output logic                victimDirty,
  output logic                flushDirty,
  output logic                flushLast
);
  localparam int OFF_W = 2;
  localparam int TAG_W = ADDR_W - OFF_W - SET_W;
  localparam int SETS  = 1 << SET_W;

  logic [TAG_W-1:0] tagArr   [2][SETS];
  logic [31:0]      dataArr  [2][SETS];
  logic             validArr [2][SETS];
  logic             dirtyArr [2][SETS];
  logic             lruArr   [SETS];
  logic [SET_W:0]   flushIdx;
  logic [31:0]      capWord;

  logic [TAG_W-1:0] addrTag;
  logic [SET_W-1:0] addrSet;
  logic [1:0]       addrOff;
  logic             hitWay, victimWay, fWay;
  logic [SET_W-1:0] fSet;
  logic [1:0]       wayHit;
  logic [31:0]      rdWord;

  assign addrTag = cpuAddr[ADDR_W-1 -: TAG_W];
  assign addrSet = cpuAddr[OFF_W +: SET_W];
  assign addrOff = cpuAddr[1:0];
  assign fWay    = flushIdx[0];
  assign fSet    = flushIdx[SET_W:1];

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign wayHit[w] = validArr[w][addrSet] && (tagArr[w][addrSet] == addrTag);
  end

  assign hit         = |wayHit;
  assign hitWay      = wayHit[1];
  assign victimWay   = lruArr[addrSet];
  assign victimDirty = validArr[victimWay][addrSet] && dirtyArr[victimWay][addrSet];
  assign flushDirty  = validArr[fWay][fSet] && dirtyArr[fWay][fSet];
  assign flushLast   = &flushIdx;

  assign rdWord   = stb.useCap ? capWord : dataArr[hitWay][addrSet];
  assign cpuRdata = rdWord[{addrOff, 3'b000} +: 8];

  always_comb begin
    unique case (stb.memSrc)
      SRC_VICTIM: begin
        memAddr  = {tagArr[victimWay][addrSet], addrSet};
        memWdata = dataArr[victimWay][addrSet];
        memBe    = 4'hF;
      end
      SRC_FLUSH: begin
        memAddr  = {tagArr[fWay][fSet], fSet};
        memWdata = dataArr[fWay][fSet];
        memBe    = 4'hF;
      end
      default: begin
        memAddr  = cpuAddr[ADDR_W-1:OFF_W];
        memWdata = {4{cpuWdata}};
        memBe    = 4'b0001 << addrOff;
      end
    endcase
  end

  // line state bits: cleared by reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validArr[0][s] <= 1'b0;
        validArr[1][s] <= 1'b0;
        dirtyArr[0][s] <= 1'b0;
        dirtyArr[1][s] <= 1'b0;
        lruArr[s]      <= 1'b0;
      end
      flushIdx <= '0;
      capWord  <= '0;
    end else begin
      if (stb.fill) begin
        validArr[victimWay][addrSet] <= 1'b1;
        dirtyArr[victimWay][addrSet] <= 1'b0;
        lruArr[addrSet]              <= ~victimWay;
      end
      if (stb.lruTouch) lruArr[addrSet] <= ~hitWay;
      if (stb.setDirty) dirtyArr[hitWay][addrSet] <= 1'b1;
      if (stb.capture)  capWord <= memRdata;
      if (stb.flushClr) flushIdx <= '0;
      if (stb.flushClean) dirtyArr[fWay][fSet] <= 1'b0;
      if (stb.flushAdv) begin
        validArr[fWay][fSet] <= 1'b0;
        dirtyArr[fWay][fSet] <= 1'b0;
        flushIdx             <= flushIdx + 1'b1;
      end
    end
  end

  // tag and data storage: no reset needed
  always_ff @(posedge clk) begin
    if (stb.fill) begin
      dataArr[victimWay][addrSet] <= memRdata;
      tagArr[victimWay][addrSet]  <= addrTag;
    end
    if (stb.writeByte) dataArr[hitWay][addrSet][{addrOff, 3'b000} +: 8] <= cpuWdata;
  end
endmodule

// File: rtl/cacheControl.sv
module cacheControl
  import cacheCtrlPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cacheDisable,
  input  logic     noWriteThrough,
  input  logic     cpuReq,
  input  logic     cpuWe,
  input  logic     flushReq,
  input  logic     memAck,
  input  logic     hit,
  input  logic     victimDirty,
  input  logic     flushDirty,
  input  logic     flushLast,
  output strobes_t stb,
  output logic     cpuReady,
  output logic     memReq,
  output logic     memWe,
  output logic     flushDone
);
  typedef enum logic [2:0] {
    S_IDLE, S_EVICT, S_FILL, S_BYP, S_WT, S_RESP, S_FLUSH, S_FDONE
  } state_e;

  state_e state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt        = state;
    stb        = '0;
    stb.memSrc = SRC_CPU;
    cpuReady   = 1'b0;
    memReq     = 1'b0;
    memWe      = 1'b0;
    flushDone  = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (flushReq) begin
          stb.flushClr = 1'b1;
          nxt          = S_FLUSH;
        end else if (cpuReq) begin
          if (cacheDisable) nxt = S_BYP;
          else if (hit) begin
            stb.lruTouch = 1'b1;
            if (!cpuWe) cpuReady = 1'b1;
            else begin
              stb.writeByte = 1'b1;
              if (noWriteThrough) begin
                stb.setDirty = 1'b1;
                cpuReady     = 1'b1;
              end else nxt = S_WT;
            end
          end
          else if (cpuWe && !noWriteThrough) nxt = S_WT;
          else if (victimDirty)              nxt = S_EVICT;
          else                               nxt = S_FILL;
        end
      end
      S_EVICT: begin
        memReq     = 1'b1;
        memWe      = 1'b1;
        stb.memSrc = SRC_VICTIM;
        if (memAck) nxt = S_FILL;
      end
      S_FILL: begin
        memReq = 1'b1;
        if (memAck) begin
          stb.fill = 1'b1;
          nxt      = S_IDLE;
        end
      end
      S_BYP: begin
        memReq = 1'b1;
        memWe  = cpuWe;
        if (memAck) begin
          stb.capture = 1'b1;
          nxt         = S_RESP;
        end
      end
      S_WT: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) nxt = S_RESP;
      end
      S_RESP: begin
        cpuReady   = 1'b1;
        stb.useCap = 1'b1;
        nxt        = S_IDLE;
      end
      S_FLUSH: begin
        stb.memSrc = SRC_FLUSH;
        if (flushDirty) begin
          memReq = 1'b1;
          memWe  = 1'b1;
          if (memAck) stb.flushClean = 1'b1;
        end else begin
          stb.flushAdv = 1'b1;
          if (flushLast) nxt = S_FDONE;
        end
      end
      S_FDONE: begin
        flushDone = 1'b1;
        nxt       = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end
endmodule

// File: rtl/setAssocCache.sv
module setAssocCache
  import cacheCtrlPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SET_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cacheDisable,
  input  logic              noWriteThrough,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [7:0]        cpuWdata,
  output logic [7:0]        cpuRdata,
  output logic              cpuReady,
  input  logic              flushReq,
  output logic              flushDone,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-3:0] memAddr,
  output logic [3:0]        memBe,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memAck
);
  strobes_t stb;
  logic     hit, victimDirty, flushDirty, flushLast;

  cacheControl ctrl_i (
    .clk(clk), .rstN(rstN), .cacheDisable(cacheDisable), .noWriteThrough(noWriteThrough),
    .cpuReq(cpuReq), .cpuWe(cpuWe), .flushReq(flushReq), .memAck(memAck),
    .hit(hit), .victimDirty(victimDirty), .flushDirty(flushDirty), .flushLast(flushLast),
    .stb(stb), .cpuReady(cpuReady), .memReq(memReq), .memWe(memWe), .flushDone(flushDone)
  );

  cacheDatapath #(.ADDR_W(ADDR_W), .SET_W(SET_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata), .memAddr(memAddr), .memWdata(memWdata), .memBe(memBe),
    .memRdata(memRdata), .hit(hit), .victimDirty(victimDirty),
    .flushDirty(flushDirty), .flushLast(flushLast)
  );
endmodule

// File: rtl/setAssocCacheChecker.sv
module setAssocCacheChecker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReq,
  input logic              cpuReady,
  input logic              flushDone,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [3:0]        memBe,
  input logic [ADDR_W-3:0] memAddr
);
  // R2: a completion answers a pending request
  a_r2_ready_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> cpuReq);

  // R2: a completing access has no memory transfer in flight
  a_r2_ready_no_mem: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> !memReq);

  // R12: request persists until acknowledged
  a_r12_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq);

  // R12: address and direction persist until acknowledged
  a_r12_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> ($stable(memAddr) && $stable(memWe)));

  // R10: completion strobe lasts one cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    flushDone |=> !flushDone);

  // R7, R5: a memory write is either one byte or a whole word
  a_r7_write_enables: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> (memBe == 4'hF || $countones(memBe) == 1));
endmodule

bind setAssocCache setAssocCacheChecker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuReady(cpuReady), .flushDone(flushDone),
  .memReq(memReq), .memWe(memWe), .memAck(memAck), .memBe(memBe), .memAddr(memAddr)
);

// File: tb/setAssocCache_tb_top.sv
`timescale 1ns/1ps
module setAssocCache_tb_top;
  localparam int ADDR_W = 24;
  localparam int SET_W  = 6;
  localparam int TAG_W  = ADDR_W - 2 - SET_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cacheDisable = 1'b0, noWriteThrough = 1'b1;
  logic cpuReq = 1'b0, cpuWe = 1'b0, flushReq = 1'b0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic [7:0] cpuWdata = '0, cpuRdata;
  logic cpuReady, flushDone, memReq, memWe;
  logic memAck = 1'b0;
  logic [ADDR_W-3:0] memAddr;
  logic [3:0] memBe;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;

  int checks = 0, errors = 0;
  int memReads = 0, memWrites = 0, opSeq = 0, lastRdSeq = 0, lastWrSeq = 0;
  logic [3:0] lastBe = '0;
  logic [31:0] memArr [logic [ADDR_W-3:0]];

  always #2 clk = ~clk;

  setAssocCache #(.ADDR_W(ADDR_W), .SET_W(SET_W)) dut_i (
    .clk(clk), .rstN(rstN), .cacheDisable(cacheDisable), .noWriteThrough(noWriteThrough),
    .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata), .cpuReady(cpuReady), .flushReq(flushReq), .flushDone(flushDone),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memBe(memBe),
    .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck)
  );

  function automatic logic [31:0] initWord(input logic [ADDR_W-3:0] a);
    return {~a[7:0], a[7:0] ^ 8'h3C, a[15:8], a[ADDR_W-3 -: 8]};
  endfunction

  function automatic logic [31:0] memRead(input logic [ADDR_W-3:0] a);
    return memArr.exists(a) ? memArr[a] : initWord(a);
  endfunction

  function automatic logic [ADDR_W-1:0] mk(input logic [TAG_W-1:0] t,
                                           input logic [SET_W-1:0] s, input logic [1:0] o);
    return {t, s, o};
  endfunction

  function automatic logic [7:0] byteOf(input logic [31:0] w, input logic [1:0] o);
    return w[{o, 3'b000} +: 8];
  endfunction

  // memory model: one access per request, ack one cycle later
  always @(posedge clk) begin
    if (memReq && !memAck) begin
      logic [31:0] w;
      memAck <= 1'b1;
      opSeq++;
      if (memWe) begin
        w = memRead(memAddr);
        for (int b = 0; b < 4; b++) if (memBe[b]) w[8*b +: 8] = memWdata[8*b +: 8];
        memArr[memAddr] = w;
        memWrites++;
        lastWrSeq = opSeq;
        lastBe = memBe;
      end else begin
        memRdata <= memRead(memAddr);
        memReads++;
        lastRdSeq = opSeq;
      end
    end else memAck <= 1'b0;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [ADDR_W-1:0] a,
                        input logic [7:0] wd, output logic [7:0] rd);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = a; cpuWdata = wd;
    #1;
    while (!cpuReady) begin @(negedge clk); #1; end
    rd = cpuRdata;
    @(posedge clk); #1;
    cpuReq = 1'b0; cpuWe = 1'b0;
  endtask

  task automatic tReset();
    @(negedge clk);
    check("R11 ready", cpuReady, 0);
    check("R11 memReq", memReq, 0);
    check("R11 flushDone", flushDone, 0);
  endtask

  task automatic tReadMissHit();
    logic [7:0] rd; int r0;
    logic [ADDR_W-1:0] a = mk(16'h0011, 6'd1, 2'd1);
    r0 = memReads;
    access(0, a, 0, rd);
    check("R11 R3 miss after reset reads", memReads - r0, 1);
    check("R3 miss byte", rd, byteOf(initWord(a[ADDR_W-1:2]), 2'd1));
    r0 = memReads;
    access(0, mk(16'h0011, 6'd1, 2'd3), 0, rd);
    check("R2 hit reads", memReads - r0, 0);
    check("R1 R2 hit byte offset 3", rd, byteOf(initWord(a[ADDR_W-1:2]), 2'd3));
  endtask

  task automatic tTwoWayLru();
    logic [7:0] rd; int r0;
    logic [ADDR_W-1:0] a = mk(16'h0011, 6'd1, 2'd0);
    logic [ADDR_W-1:0] b = mk(16'h0022, 6'd1, 2'd2);
    logic [ADDR_W-1:0] c = mk(16'h0033, 6'd1, 2'd0);
    access(0, b, 0, rd);
    r0 = memReads;
    access(0, a, 0, rd);
    access(0, b, 0, rd);
    check("R3 two blocks coexist", memReads - r0, 0);
    check("R3 second way byte", rd, byteOf(initWord(b[ADDR_W-1:2]), 2'd2));
    access(0, a, 0, rd);           // a now most recent
    r0 = memReads;
    access(0, c, 0, rd);
    check("R1 R4 third block misses", memReads - r0, 1);
    r0 = memReads;
    access(0, a, 0, rd);
    check("R4 recent block kept", memReads - r0, 0);
    access(0, b, 0, rd);
    check("R4 older block evicted", memReads - r0, 1);
  endtask

  task automatic tWriteBack();
    logic [7:0] rd; int r0, w0;
    logic [ADDR_W-1:0] a = mk(16'h0044, 6'd2, 2'd0);
    logic [ADDR_W-1:0] b = mk(16'h0055, 6'd2, 2'd0);
    logic [ADDR_W-1:0] c = mk(16'h0066, 6'd2, 2'd0);
    logic [31:0] expW;
    noWriteThrough = 1'b1;
    r0 = memReads; w0 = memWrites;
    access(1, a, 8'hC3, rd);
    check("R5 write miss allocates", memReads - r0, 1);
    check("R5 R6 no memory write", memWrites - w0, 0);
    check("R5 memory untouched", memRead(a[ADDR_W-1:2]), initWord(a[ADDR_W-1:2]));
    r0 = memReads;
    access(0, a, 0, rd);
    check("R5 cached byte", rd, 8'hC3);
    check("R5 read back hits", memReads - r0, 0);
    access(0, b, 0, rd);
    check("R6 fill into invalid way", memWrites - w0, 0);
    r0 = memReads;
    access(0, c, 0, rd);
    check("R5 dirty victim written", memWrites - w0, 1);
    check("R5 full word enables", lastBe, 4'hF);
    check("R5 write before fill", lastWrSeq < lastRdSeq, 1);
    expW = initWord(a[ADDR_W-1:2]);
    expW[7:0] = 8'hC3;
    check("R5 victim word", memRead(a[ADDR_W-1:2]), expW);
    check("R5 one fill read", memReads - r0, 1);
  endtask

  task automatic tWriteThrough();
    logic [7:0] rd; int r0, w0;
    logic [ADDR_W-1:0] d = mk(16'h0077, 6'd3, 2'd2);
    logic [ADDR_W-1:0] e = mk(16'h0088, 6'd4, 2'd1);
    noWriteThrough = 1'b0;
    access(0, d, 0, rd);
    r0 = memReads; w0 = memWrites;
    access(1, d, 8'h5A, rd);
    check("R7 hit writes memory", memWrites - w0, 1);
    check("R7 byte enable offset 2", lastBe, 4'b0100);
    check("R7 memory byte", byteOf(memRead(d[ADDR_W-1:2]), 2'd2), 8'h5A);
    access(0, d, 0, rd);
    check("R7 cache updated", rd, 8'h5A);
    check("R7 no reads", memReads - r0, 0);
    w0 = memWrites;
    access(1, e, 8'h3C, rd);
    check("R8 miss writes memory", memWrites - w0, 1);
    check("R8 no allocate read", memReads - r0, 0);
    access(0, e, 0, rd);
    check("R8 later read misses", memReads - r0, 1);
    check("R8 later read byte", rd, 8'h3C);
  endtask

  task automatic tDisable();
    logic [7:0] rd; int r0, w0;
    logic [ADDR_W-1:0] a = mk(16'h0011, 6'd1, 2'd1);
    logic [ADDR_W-1:0] h = mk(16'h0099, 6'd5, 2'd3);
    cacheDisable = 1'b1;
    r0 = memReads; w0 = memWrites;
    access(0, a, 0, rd);
    check("R9 cached block still read", memReads - r0, 1);
    check("R9 bypass byte", rd, byteOf(initWord(a[ADDR_W-1:2]), 2'd1));
    access(1, h, 8'hE7, rd);
    check("R9 bypass write", memWrites - w0, 1);
    check("R9 bypass memory byte", byteOf(memRead(h[ADDR_W-1:2]), 2'd3), 8'hE7);
    cacheDisable = 1'b0;
  endtask

  task automatic tFlush();
    logic [7:0] rd; int r0, w0, cyc;
    logic [ADDR_W-1:0] f = mk(16'h00AA, 6'd6, 2'd0);
    logic [ADDR_W-1:0] g = mk(16'h00BB, 6'd7, 2'd1);
    logic sawDone;
    noWriteThrough = 1'b1;
    access(1, f, 8'h11, rd);
    access(1, g, 8'h22, rd);
    w0 = memWrites;
    @(negedge clk); flushReq = 1'b1;
    sawDone = 1'b0; cyc = 0;
    while (!sawDone && cyc < 1000) begin
      @(negedge clk); cyc++;
      if (flushDone) sawDone = 1'b1;
    end
    @(posedge clk); #1; flushReq = 1'b0;
    check("R10 done seen", sawDone, 1);
    check("R10 dirty lines written", memWrites - w0, 2);
    check("R10 line f", byteOf(memRead(f[ADDR_W-1:2]), 2'd0), 8'h11);
    check("R10 line g", byteOf(memRead(g[ADDR_W-1:2]), 2'd1), 8'h22);
    @(negedge clk);
    check("R10 done one cycle", flushDone, 0);
    r0 = memReads;
    access(0, f, 0, rd);
    check("R10 invalid after flush", memReads - r0, 1);
    check("R10 refetched byte", rd, 8'h11);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tReset();
    tReadMissHit();
    tTwoWayLru();
    tWriteBack();
    tWriteThrough();
    tDisable();
    tFlush();
    repeat (4) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule